// File: doc/BRIEF.md
# SPI NOR Flash Hardware Sequencer

This block runs whole SPI NOR flash operations for a host that sees only a few memory-mapped registers. The host sets a 24-bit flash address, a byte count and a 4-bit cycle code, then writes a start bit. The sequencer picks the SPI command and the frame layout. It sends a write-enable frame on its own when the cycle needs one. It moves data through a 64-byte buffer and, after programming or erasing, polls the flash status byte until the part is idle again.

Progress shows in one control/status word. A busy bit is high while frames are on the wire. When the cycle ends, exactly one of three sticky flags is set: done, cycle error or access error. The host clears each flag by writing a 1 to it. The SPI port is a single-lane master that drives data on the falling clock edge and samples on the rising edge. The clock is low while idle and chip select is high between frames.

Top module: `spi_hwseq`

## Requirements
- R1: After reset the control word (byte offset 0x04) reads 0, chip select is high and the SPI clock is low.
- R2: Cycle code 0 (read) sends one frame: command 0x03, then the address MSB first (address word at offset 0x08, bits 23:0). It then clocks in count+1 bytes, where count is the 6-bit field at control bits 29:24. Byte k is stored in buffer dword k/4 (offset 0x10+4·n), lane k mod 4, so the buffer is little-endian.
- R3: The busy bit (control bit 5) is 1 from the cycle that accepts a start until the cycle ends. Chip select is high and the SPI clock low whenever no cycle runs.
- R4: Cycle code 2 (page write) sends a lone 0x06 frame, then 0x02 with the address and count+1 bytes taken from the buffer in little-endian order. It then sends repeated 0x05 frames of one status byte each until bit 0 of the status byte reads 0. Then it sets done (control bit 0).
- R5: Cycle code 3 (4 KiB erase, command 0x20) and code 4 (64 KiB erase, command 0xD8) each send 0x06, then the command with the address and no data, then status polling as in R4.
- R6: Cycle code 6 (identify, 0x9F) and code 8 (status read, 0x05) send the command with no address and store count+1 returned bytes as in R2.
- R7: Cycle code 7 (status write) sends 0x06, then 0x01 followed by count+1 buffer bytes, and sets done with no status polling.
- R8: A start with any code other than 0, 2, 3, 4, 6, 7, 8 sets the cycle-error flag (bit 1) one clock later. No SPI frame is sent and busy never rises.
- R9: While busy, writes to the control word fields, the start bit, the address word and the buffer have no effect.
- R10: Control bits 0, 1 and 2 clear when a 1 is written to them. A new accepted start clears all three. At most one of them is ever set.
- R11: Control bit 15 (lock) is set by writing 1 and stays set until reset. While it is set, a start of code 2, 3, 4 or 7 sets the access-error flag (bit 2) with no SPI frame; other cycles still run.
- R12: If POLL_LIMIT status reads in a row all show bit 0 set, the cycle ends with the cycle-error flag instead of done.
- R13: A count field of 63 moves 64 bytes, filling the whole buffer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe; data is valid on the next clock |
| reg_addr | input | AW | Byte offset of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| spi_sck | output | 1 | SPI clock, idle low |
| spi_cs_n | output | 1 | SPI chip select, active low |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |

## Verification
A sequencer that is in the wrong state leaves the frame boundaries wrong on the wire. A frame has a missing or extra byte, a write-enable frame is missing, or polling stops early. A flash model that logs every byte of every frame shows this in the same cycle run. Wrong buffer lane or index logic shows up as soon as the buffer is read back after a read cycle. Stuck flag, lock or busy logic shows in the control word one clock after the write that should have changed it.

// File: rtl/spi_hwseq_pkg.sv
package spi_hwseq_pkg;

  localparam logic [3:0] CY_READ  = 4'd0;
  localparam logic [3:0] CY_PROG  = 4'd2;
  localparam logic [3:0] CY_ER4K  = 4'd3;
  localparam logic [3:0] CY_ER64K = 4'd4;
  localparam logic [3:0] CY_IDENT = 4'd6;
  localparam logic [3:0] CY_WSTAT = 4'd7;
  localparam logic [3:0] CY_RSTAT = 4'd8;

  localparam logic [7:0] OP_WREN = 8'h06;
  localparam logic [7:0] OP_RSTAT = 8'h05;

  typedef enum logic [3:0] {
    S_IDLE, S_WREN, S_GAP, S_CMD, S_ADDR, S_DATA, S_POLLC, S_POLLD, S_FIN
  } seq_state_e;

  function automatic logic cyc_known(input logic [3:0] t);
    return t inside {CY_READ, CY_PROG, CY_ER4K, CY_ER64K, CY_IDENT, CY_WSTAT, CY_RSTAT};
  endfunction

  function automatic logic cyc_modifies(input logic [3:0] t);
    return t inside {CY_PROG, CY_ER4K, CY_ER64K, CY_WSTAT};
  endfunction

  function automatic logic cyc_polls(input logic [3:0] t);
    return t inside {CY_PROG, CY_ER4K, CY_ER64K};
  endfunction

  function automatic logic cyc_has_addr(input logic [3:0] t);
    return t inside {CY_READ, CY_PROG, CY_ER4K, CY_ER64K};
  endfunction

  function automatic logic cyc_has_data(input logic [3:0] t);
    return !(t inside {CY_ER4K, CY_ER64K});
  endfunction

  function automatic logic cyc_data_in(input logic [3:0] t);
    return t inside {CY_READ, CY_IDENT, CY_RSTAT};
  endfunction

  function automatic logic [7:0] cyc_opcode(input logic [3:0] t);
    case (t)
      CY_READ:  return 8'h03;
      CY_PROG:  return 8'h02;
      CY_ER4K:  return 8'h20;
      CY_ER64K: return 8'hD8;
      CY_IDENT: return 8'h9F;
      CY_WSTAT: return 8'h01;
      default:  return OP_RSTAT;
    endcase
  endfunction

  function automatic logic in_frame(input seq_state_e s);
    return s inside {S_WREN, S_CMD, S_ADDR, S_DATA, S_POLLC, S_POLLD};
  endfunction

endpackage

// File: rtl/spi_hwseq_shifter.sv
module spi_hwseq_shifter #(
  parameter int SCK_HALF = 1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic [7:0] tx,
  input  logic       miso,
  output logic       sck,
  output logic       mosi,
  output logic       done,
  output logic [7:0] rx
);
  localparam int DW = (SCK_HALF > 1) ? $clog2(SCK_HALF) : 1;

  logic          active;
  logic [DW-1:0] div;
  logic [2:0]    bitn;
  logic [7:0]    sr;

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      div    <= '0;
      bitn   <= '0;
      sr     <= '0;
      rx     <= '0;
      sck    <= 1'b0;
      mosi   <= 1'b0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!active) begin
        if (start) begin
          active <= 1'b1;
          sr     <= tx;
          mosi   <= tx[7];
          bitn   <= '0;
          div    <= '0;
        end
      end else if (div != DW'(SCK_HALF - 1)) begin
        div <= div + 1'b1;
      end else begin
        div <= '0;
        if (!sck) begin
          sck <= 1'b1;
          rx  <= {rx[6:0], miso};
        end else begin
          sck <= 1'b0;
          if (bitn == 3'd7) begin
            active <= 1'b0;
            done   <= 1'b1;
          end else begin
            bitn <= bitn + 1'b1;
            sr   <= {sr[6:0], 1'b0};
            mosi <= sr[6];
          end
        end
      end
    end
  end
endmodule

// File: rtl/spi_hwseq_buf.sv
module spi_hwseq_buf #(
  parameter int WORDS = 16,
  localparam int IW = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [IW-1:0] widx,
  input  logic [3:0]    wbe,
  input  logic [31:0]   wdata,
  input  logic [IW-1:0] ridx_a,
  output logic [31:0]   rdata_a,
  input  logic [IW-1:0] ridx_b,
  output logic [31:0]   rdata_b
);
  logic [31:0] mem [WORDS];

  always_ff @(posedge clk) begin
    if (we) begin
      for (int b = 0; b < 4; b++) begin
        if (wbe[b]) mem[widx][8*b +: 8] <= wdata[8*b +: 8];
      end
    end
  end

  assign rdata_a = mem[ridx_a];
  assign rdata_b = mem[ridx_b];
endmodule

// File: rtl/spi_hwseq_engine.sv
module spi_hwseq_engine
  import spi_hwseq_pkg::*;
#(
  parameter int BUF_BYTES  = 64,
  parameter int SCK_HALF   = 1,
  parameter int CS_GAP     = 2,
  parameter int POLL_LIMIT = 1024,
  localparam int CW = $clog2(BUF_BYTES),
  localparam int IW = $clog2(BUF_BYTES / 4)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [3:0]    type_in,
  input  logic [23:0]   addr_in,
  input  logic [CW-1:0] cnt_in,
  input  logic [31:0]   buf_rdata,
  output logic [IW-1:0] buf_ridx,
  output logic          buf_we,
  output logic [IW-1:0] buf_widx,
  output logic [3:0]    buf_wbe,
  output logic [31:0]   buf_wdata,
  output logic          busy,
  output logic          fin,
  output logic          fin_err,
  output logic          sck,
  output logic          mosi,
  output logic          cs_n,
  input  logic          miso
);
  localparam int GW = $clog2(CS_GAP + 1);
  localparam int PW = $clog2(POLL_LIMIT + 1);

  seq_state_e    st, st_n, after, after_n;
  logic [3:0]    cyc;
  logic [23:0]   fla;
  logic [CW-1:0] last, k;
  logic [1:0]    ai;
  logic [GW-1:0] gapcnt;
  logic [PW-1:0] polls;
  logic          inflight, err;

  logic          sh_start, sh_done;
  logic [7:0]    sh_tx, sh_rx;

  spi_hwseq_shifter #(.SCK_HALF(SCK_HALF)) u_shift (
    .clk(clk), .rst(rst), .start(sh_start), .tx(sh_tx), .miso(miso),
    .sck(sck), .mosi(mosi), .done(sh_done), .rx(sh_rx)
  );

  assign busy     = (st != S_IDLE);
  assign fin      = (st == S_FIN);
  assign fin_err  = err;
  assign buf_ridx = k[CW-1:2];
  assign sh_start = in_frame(st) && !inflight;

  always_comb begin
    case (st)
      S_WREN:  sh_tx = OP_WREN;
      S_CMD:   sh_tx = cyc_opcode(cyc);
      S_ADDR:  sh_tx = (ai == 2'd0) ? fla[23:16] : (ai == 2'd1) ? fla[15:8] : fla[7:0];
      S_DATA:  sh_tx = cyc_data_in(cyc) ? 8'h00 : buf_rdata[8*k[1:0] +: 8];
      S_POLLC: sh_tx = OP_RSTAT;
      default: sh_tx = 8'h00;
    endcase
  end

  always_comb begin
    buf_we    = (st == S_DATA) && sh_done && cyc_data_in(cyc);
    buf_widx  = k[CW-1:2];
    buf_wbe   = 4'b0001 << k[1:0];
    buf_wdata = {4{sh_rx}};
  end

  always_comb begin
    st_n    = st;
    after_n = after;
    case (st)
      S_IDLE:  if (start) st_n = cyc_modifies(type_in) ? S_WREN : S_CMD;
      S_WREN:  if (sh_done) begin st_n = S_GAP; after_n = S_CMD; end
      S_GAP:   if (gapcnt == GW'(CS_GAP - 1)) st_n = after;
      S_CMD:   if (sh_done) st_n = cyc_has_addr(cyc) ? S_ADDR : S_DATA;
      S_ADDR:  if (sh_done && ai == 2'd2) begin
                 if (cyc_has_data(cyc)) st_n = S_DATA;
                 else begin st_n = S_GAP; after_n = S_POLLC; end
               end
      S_DATA:  if (sh_done && k == last) begin
                 if (cyc_polls(cyc)) begin st_n = S_GAP; after_n = S_POLLC; end
                 else st_n = S_FIN;
               end
      S_POLLC: if (sh_done) st_n = S_POLLD;
      S_POLLD: if (sh_done) begin
                 if (!sh_rx[0] || polls == PW'(POLL_LIMIT - 1)) st_n = S_FIN;
                 else begin st_n = S_GAP; after_n = S_POLLC; end
               end
      default: st_n = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= S_IDLE;
      after    <= S_IDLE;
      cs_n     <= 1'b1;
      cyc      <= '0;
      fla      <= '0;
      last     <= '0;
      k        <= '0;
      ai       <= '0;
      gapcnt   <= '0;
      polls    <= '0;
      inflight <= 1'b0;
      err      <= 1'b0;
    end else begin
      st    <= st_n;
      after <= after_n;
      cs_n  <= !in_frame(st_n);
      if (sh_start) inflight <= 1'b1;
      else if (sh_done) inflight <= 1'b0;
      gapcnt <= (st == S_GAP) ? gapcnt + 1'b1 : '0;
      if (st == S_IDLE && start) begin
        cyc   <= type_in;
        fla   <= addr_in;
        last  <= cnt_in;
        k     <= '0;
        ai    <= '0;
        polls <= '0;
        err   <= 1'b0;
      end
      if (sh_done) begin
        if (st == S_ADDR) ai <= ai + 1'b1;
        if (st == S_DATA) k <= k + 1'b1;
        if (st == S_POLLD) begin
          polls <= polls + 1'b1;
          if (sh_rx[0] && polls == PW'(POLL_LIMIT - 1)) err <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/spi_hwseq.sv
module spi_hwseq
  import spi_hwseq_pkg::*;
#(
  parameter int BUF_BYTES  = 64,
  parameter int SCK_HALF   = 1,
  parameter int CS_GAP     = 2,
  parameter int POLL_LIMIT = 1024,
  parameter int AW         = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [AW-1:0] reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  output logic          spi_sck,
  output logic          spi_cs_n,
  output logic          spi_mosi,
  input  logic          spi_miso
);
  localparam int WORDS     = BUF_BYTES / 4;
  localparam int IW        = $clog2(WORDS);
  localparam int CW        = $clog2(BUF_BYTES);
  localparam int OFF_CTRL  = 4;
  localparam int OFF_ADDR  = 8;
  localparam int OFF_DATA  = 16;
  localparam int CNT_LSB   = 24;
  localparam int TYPE_LSB  = 17;
  localparam int GO_BIT    = 16;
  localparam int LOCK_BIT  = 15;
  localparam int BUSY_BIT  = 5;

  logic          hit_ctrl, hit_addr, hit_data;
  logic [IW-1:0] cpu_idx;
  logic          flg_done, flg_cerr, flg_aerr, lock;
  logic [3:0]    cyc_type;
  logic [CW-1:0] cyc_cnt;
  logic [23:0]   fla;
  logic          eng_busy, eng_fin, eng_err;
  logic          go, legal, refused, eng_start;
  logic [3:0]    wtype;
  logic [IW-1:0] e_ridx, e_widx;
  logic          e_we;
  logic [3:0]    e_wbe;
  logic [31:0]   e_wdata, e_rdata, cpu_rdata;
  logic          m_we;
  logic [IW-1:0] m_idx;
  logic [3:0]    m_be;
  logic [31:0]   m_wdata, ctrl_word;
  logic          unused_wbits;

  assign unused_wbits = ^{reg_wdata[31:CNT_LSB+CW], reg_wdata[CNT_LSB-1:TYPE_LSB+4],
                          reg_wdata[14:3], reg_wdata[31:24] & 8'h00};

  assign hit_ctrl = (reg_addr == AW'(OFF_CTRL));
  assign hit_addr = (reg_addr == AW'(OFF_ADDR));
  assign hit_data = (reg_addr >= AW'(OFF_DATA)) && (reg_addr < AW'(OFF_DATA + 4 * WORDS))
                    && (reg_addr[1:0] == 2'b00);
  assign cpu_idx  = IW'((reg_addr - AW'(OFF_DATA)) >> 2);

  assign wtype     = reg_wdata[TYPE_LSB +: 4];
  assign go        = reg_wr && hit_ctrl && reg_wdata[GO_BIT] && !eng_busy;
  assign legal     = cyc_known(wtype);
  assign refused   = lock && cyc_modifies(wtype);
  assign eng_start = go && legal && !refused;

  always_comb begin
    m_we    = e_we || (reg_wr && hit_data && !eng_busy);
    m_idx   = e_we ? e_widx : cpu_idx;
    m_be    = e_we ? e_wbe : 4'hF;
    m_wdata = e_we ? e_wdata : reg_wdata;
  end

  spi_hwseq_buf #(.WORDS(WORDS)) u_buf (
    .clk(clk), .we(m_we), .widx(m_idx), .wbe(m_be), .wdata(m_wdata),
    .ridx_a(cpu_idx), .rdata_a(cpu_rdata), .ridx_b(e_ridx), .rdata_b(e_rdata)
  );

  spi_hwseq_engine #(
    .BUF_BYTES(BUF_BYTES), .SCK_HALF(SCK_HALF), .CS_GAP(CS_GAP), .POLL_LIMIT(POLL_LIMIT)
  ) u_eng (
    .clk(clk), .rst(rst), .start(eng_start), .type_in(wtype), .addr_in(fla),
    .cnt_in(reg_wdata[CNT_LSB +: CW]), .buf_rdata(e_rdata), .buf_ridx(e_ridx),
    .buf_we(e_we), .buf_widx(e_widx), .buf_wbe(e_wbe), .buf_wdata(e_wdata),
    .busy(eng_busy), .fin(eng_fin), .fin_err(eng_err),
    .sck(spi_sck), .mosi(spi_mosi), .cs_n(spi_cs_n), .miso(spi_miso)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      flg_done <= 1'b0;
      flg_cerr <= 1'b0;
      flg_aerr <= 1'b0;
      lock     <= 1'b0;
      cyc_type <= '0;
      cyc_cnt  <= '0;
      fla      <= '0;
    end else begin
      if (reg_wr && hit_ctrl) begin
        if (reg_wdata[0]) flg_done <= 1'b0;
        if (reg_wdata[1]) flg_cerr <= 1'b0;
        if (reg_wdata[2]) flg_aerr <= 1'b0;
        if (reg_wdata[LOCK_BIT]) lock <= 1'b1;
        if (!eng_busy) begin
          cyc_type <= wtype;
          cyc_cnt  <= reg_wdata[CNT_LSB +: CW];
        end
      end
      if (reg_wr && hit_addr && !eng_busy) fla <= reg_wdata[23:0];
      if (go) begin
        flg_done <= 1'b0;
        flg_cerr <= !legal;
        flg_aerr <= legal && refused;
      end
      if (eng_fin) begin
        flg_done <= !eng_err;
        flg_cerr <= eng_err;
      end
    end
  end

  always_comb begin
    ctrl_word                  = '0;
    ctrl_word[CNT_LSB +: CW]   = cyc_cnt;
    ctrl_word[TYPE_LSB +: 4]   = cyc_type;
    ctrl_word[LOCK_BIT]        = lock;
    ctrl_word[BUSY_BIT]        = eng_busy;
    ctrl_word[2:0]             = {flg_aerr, flg_cerr, flg_done};
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else if (reg_rd) begin
      if (hit_ctrl)      reg_rdata <= ctrl_word;
      else if (hit_addr) reg_rdata <= {8'h00, fla};
      else if (hit_data) reg_rdata <= cpu_rdata;
      else               reg_rdata <= '0;
    end
  end
endmodule

// File: rtl/spi_hwseq_chk.sv
module spi_hwseq_chk #(
  parameter int AW = 7
) (
  input logic          clk,
  input logic          rst,
  input logic          reg_wr,
  input logic [AW-1:0] reg_addr,
  input logic [31:0]   reg_wdata,
  input logic          busy,
  input logic          cs_n,
  input logic          sck,
  input logic          lock,
  input logic          f_done,
  input logic          f_cerr,
  input logic          f_aerr,
  input logic [3:0]    cyc_type
);
  logic ctrl_wr, go_try, bad_code, mod_code;
  assign ctrl_wr  = reg_wr && (reg_addr == AW'(4));
  assign go_try   = ctrl_wr && reg_wdata[16] && !busy;
  assign bad_code = !(reg_wdata[20:17] inside {4'd0, 4'd2, 4'd3, 4'd4, 4'd6, 4'd7, 4'd8});
  assign mod_code = reg_wdata[20:17] inside {4'd2, 4'd3, 4'd4, 4'd7};

  assert_idle_cs_R3: assert property (@(posedge clk) disable iff (rst) !busy |-> cs_n);
  assert_cs_sck_R3: assert property (@(posedge clk) disable iff (rst) cs_n |-> !sck);
  assert_bad_code_R8: assert property (@(posedge clk) disable iff (rst)
    (go_try && bad_code) |=> (!busy && f_cerr));
  assert_busy_fields_R9: assert property (@(posedge clk) disable iff (rst)
    (busy && ctrl_wr) |=> $stable(cyc_type));
  assert_one_flag_R10: assert property (@(posedge clk) disable iff (rst)
    $countones({f_done, f_cerr, f_aerr}) <= 1);
  assert_lock_sticky_R11: assert property (@(posedge clk) disable iff (rst) lock |=> lock);
  assert_lock_refuse_R11: assert property (@(posedge clk) disable iff (rst)
    (go_try && lock && mod_code) |=> (!busy && f_aerr));
endmodule

bind spi_hwseq spi_hwseq_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
  .busy(eng_busy), .cs_n(spi_cs_n), .sck(spi_sck), .lock(lock),
  .f_done(flg_done), .f_cerr(flg_cerr), .f_aerr(flg_aerr), .cyc_type(cyc_type)
);

// File: tb/spi_hwseq_bench.sv
`timescale 1ns/1ps
module spi_hwseq_bench;
  localparam int PL = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [6:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        spi_sck, spi_cs_n, spi_mosi;
  logic        spi_miso = 1'b0;

  int total = 0, bad = 0;

  always #2 clk = ~clk;

  spi_hwseq #(.SCK_HALF(1), .CS_GAP(2), .POLL_LIMIT(PL)) u_spi_hwseq (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .spi_sck(spi_sck),
    .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
  );

  // flash model: logs every frame, answers reads, identify and status
  logic [7:0] fb [16][72];
  int         flen [16];
  logic [7:0] m_sr = 0, m_ob = 0, m_cmd = 0;
  int         m_bit = 0, m_bi = 0, m_nfr = 0, m_wip = 0, m_wip_set = 0;

  function automatic logic [7:0] pat(input int x);
    return 8'((x * 37 + 11) & 255);
  endfunction
  function automatic logic [7:0] wpat(input int k);
    return 8'((k * 29 + 3) & 255);
  endfunction
  function automatic logic [7:0] idb(input int j);
    return (j == 0) ? 8'hC2 : (j == 1) ? 8'h20 : (j == 2) ? 8'h18 : 8'(j);
  endfunction

  always @(negedge spi_cs_n) begin m_bit = 0; m_bi = 0; m_ob = 0; end
  always @(posedge spi_sck) if (!spi_cs_n) begin
    m_sr = {m_sr[6:0], spi_mosi};
    m_bit++;
    if (m_bit == 8) begin
      m_bit = 0;
      if (m_bi == 0) m_cmd = m_sr;
      if (m_nfr < 16 && m_bi < 72) fb[m_nfr][m_bi] = m_sr;
      case (m_cmd)
        8'h03: m_ob = (m_bi >= 3) ? pat(int'({fb[m_nfr][1], fb[m_nfr][2], fb[m_nfr][3]}) + m_bi - 3) : 8'h00;
        8'h9F: m_ob = idb(m_bi);
        8'h05: m_ob = 8'h5C | ((m_wip != 0) ? 8'h01 : 8'h00);
        default: m_ob = 8'h00;
      endcase
      m_bi++;
    end
  end
  always @(negedge spi_sck) if (!spi_cs_n) spi_miso = m_ob[7 - m_bit];
  always @(posedge spi_cs_n) if (m_bi > 0) begin
    if (m_nfr < 16) flen[m_nfr] = m_bi;
    if (m_cmd == 8'h05 && m_wip > 0) m_wip--;
    if (m_cmd == 8'h02 || m_cmd == 8'h20 || m_cmd == 8'hD8) m_wip = m_wip_set;
    m_nfr++;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [6:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [6:0] a, output logic [31:0] d);
    @(negedge clk); reg_rd = 1'b1; reg_addr = a;
    @(negedge clk); d = reg_rdata; reg_rd = 1'b0;
  endtask

  function automatic logic [31:0] ctl(input int t, input int c, input bit g);
    return (32'(c) << 24) | (32'(t) << 17) | (g ? 32'h0001_0000 : 32'h0);
  endfunction

  task automatic start(input int t, input int c, input logic [23:0] a);
    m_nfr = 0;
    wr(7'h08, {8'h00, a});
    wr(7'h04, ctl(t, c, 1'b1));
  endtask

  task automatic wait_end(output logic [31:0] s);
    s = 32'h20;
    for (int i = 0; i < 4000 && (s[5] || s[2:0] == 3'b000); i++) rd(7'h04, s);
  endtask

  task automatic check_frame(input string req, input int f, input int n, input logic [7:0] b0);
    check({req, " frame length"}, 32'(flen[f]), 32'(n));
    check({req, " frame command"}, {24'h0, fb[f][0]}, {24'h0, b0});
  endtask

  task automatic check_addr(input string req, input int f, input logic [23:0] a);
    check({req, " address"}, {8'h0, fb[f][1], fb[f][2], fb[f][3]}, {8'h0, a});
  endtask

  task automatic check_buf(input string req, input int c, input int a, input int mode);
    logic [31:0] d;
    for (int w = 0; w <= c / 4; w++) begin
      rd(7'(16 + 4 * w), d);
      for (int l = 0; l < 4; l++) begin
        if (4 * w + l <= c)
          check(req, {24'h0, d[8*l +: 8]},
                {24'h0, (mode == 0) ? pat(a + 4 * w + l) : idb(4 * w + l)});
      end
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=%h expected=%h", 0, 1);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] s, d;
    int counts [10] = '{0, 1, 2, 3, 4, 5, 15, 16, 62, 63};
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    rd(7'h04, s);
    check("R1 control word", s, 32'h0);
    check("R1 chip select", {31'h0, spi_cs_n}, 32'h1);
    check("R1 clock", {31'h0, spi_sck}, 32'h0);

    // R2 / R13 read sweep over byte counts
    foreach (counts[i]) begin
      int c = counts[i];
      int a = 24'h012345 + c * 24'h010203;
      start(0, c, 24'(a));
      if (i == 0) begin
        rd(7'h04, s);
        check("R3 busy after start", {31'h0, s[5]}, 32'h1);
      end
      wait_end(s);
      check("R2 read done flags", s & 32'h27, 32'h1);
      check("R2 read frames", 32'(m_nfr), 32'h1);
      check_frame("R2 read", 0, 4 + c + 1, 8'h03);
      check_addr("R2 read", 0, 24'(a));
      check(c == 63 ? "R13 full buffer byte" : "R2 read byte", 32'h0, 32'h0);
      check_buf(c == 63 ? "R13 buffer data" : "R2 buffer data", c, a, 0);
    end
    check("R3 idle chip select", {31'h0, spi_cs_n}, 32'h1);

    // R4 page write with status polling
    for (int w = 0; w < 3; w++)
      wr(7'(16 + 4 * w), {wpat(4*w+3), wpat(4*w+2), wpat(4*w+1), wpat(4*w)});
    m_wip_set = 2;
    start(2, 9, 24'hA1B2C3);
    wait_end(s);
    check("R4 write done", s & 32'h27, 32'h1);
    check("R4 frame count", 32'(m_nfr), 32'd5);
    check_frame("R4 enable", 0, 1, 8'h06);
    check_frame("R4 program", 1, 14, 8'h02);
    check_addr("R4 program", 1, 24'hA1B2C3);
    for (int k = 0; k < 10; k++)
      check("R4 program data", {24'h0, fb[1][4 + k]}, {24'h0, wpat(k)});
    for (int f = 2; f < 5; f++) check_frame("R4 poll", f, 2, 8'h05);

    // R5 erases
    m_wip_set = 0;
    start(3, 0, 24'h003000);
    wait_end(s);
    check("R5 4K done", s & 32'h27, 32'h1);
    check("R5 4K frames", 32'(m_nfr), 32'd3);
    check_frame("R5 4K enable", 0, 1, 8'h06);
    check_frame("R5 4K erase", 1, 4, 8'h20);
    check_addr("R5 4K erase", 1, 24'h003000);
    check_frame("R5 4K poll", 2, 2, 8'h05);
    m_wip_set = 1;
    start(4, 0, 24'h7F0000);
    wait_end(s);
    check("R5 64K done", s & 32'h27, 32'h1);
    check("R5 64K frames", 32'(m_nfr), 32'd4);
    check_frame("R5 64K erase", 1, 4, 8'hD8);
    check_addr("R5 64K erase", 1, 24'h7F0000);

    // R6 identify and status read
    start(6, 3, 24'h0);
    wait_end(s);
    check("R6 ident done", s & 32'h27, 32'h1);
    check_frame("R6 ident", 0, 5, 8'h9F);
    check_buf("R6 ident data", 3, 0, 1);
    m_wip_set = 0;
    start(8, 1, 24'h0);
    wait_end(s);
    check_frame("R6 status read", 0, 3, 8'h05);
    rd(7'h10, d);
    check("R6 status bytes", d & 32'hFFFF, 32'h5C5C);

    // R7 status write
    wr(7'h10, 32'h0000_3C7A);
    start(7, 1, 24'h0);
    wait_end(s);
    check("R7 done", s & 32'h27, 32'h1);
    check("R7 frames", 32'(m_nfr), 32'd2);
    check_frame("R7 enable", 0, 1, 8'h06);
    check_frame("R7 write status", 1, 3, 8'h01);
    check("R7 data", {16'h0, fb[1][2], fb[1][1]}, 32'h3C7A);

    // R12 polling limit, both sides of the boundary
    m_wip_set = PL - 1;
    start(2, 0, 24'h000100);
    wait_end(s);
    check("R12 last poll clear done", s & 32'h27, 32'h1);
    check("R12 last poll frames", 32'(m_nfr), 32'(2 + PL));
    m_wip_set = PL;
    start(2, 0, 24'h000100);
    wait_end(s);
    check("R12 limit error", s & 32'h27, 32'h2);
    check("R12 limit frames", 32'(m_nfr), 32'(2 + PL));

    // R8 unknown codes, R10 write-one-to-clear
    foreach (counts[i]) begin end
    for (int t = 0; t < 16; t++) begin
      if (!(t inside {0, 2, 3, 4, 6, 7, 8})) begin
        start(t, 0, 24'h0);
        rd(7'h04, s);
        check("R8 unknown code flags", s, ctl(t, 0, 1'b0) | 32'h2);
        check("R8 no frame", 32'(m_nfr), 32'h0);
        wr(7'h04, 32'h2);
        rd(7'h04, s);
        check("R10 clear cycle error", s, 32'h0);
      end
    end

    // R10 a new start clears an old error
    start(5, 0, 24'h0);
    start(8, 0, 24'h0);
    wait_end(s);
    check("R10 start clears error", s & 32'h27, 32'h1);
    wr(7'h04, 32'h1);
    rd(7'h04, s);
    check("R10 clear done", s & 32'h7, 32'h0);

    // R9 writes while busy are ignored
    start(0, 63, 24'h0055AA);
    wr(7'h04, ctl(6, 5, 1'b1));
    wr(7'h08, 32'h00ABCDEF);
    wr(7'h10, 32'hDEADBEEF);
    wait_end(s);
    check("R9 fields kept", s, ctl(0, 63, 1'b0) | 32'h1);
    check("R9 single frame", 32'(m_nfr), 32'h1);
    check_frame("R9 frame", 0, 68, 8'h03);
    rd(7'h08, d);
    check("R9 address kept", d, 32'h0055AA);
    check_buf("R9 buffer from flash", 3, 24'h0055AA, 0);

    // R11 lock
    wr(7'h04, 32'h0000_8000);
    wr(7'h04, 32'h0);
    rd(7'h04, s);
    check("R11 lock sticky", {31'h0, s[15]}, 32'h1);
    for (int t = 2; t <= 7; t++) begin
      if (t inside {2, 3, 4, 7}) begin
        start(t, 0, 24'h0);
        rd(7'h04, s);
        check("R11 refused flags", s & 32'h27, 32'h4);
        check("R11 refused no frame", 32'(m_nfr), 32'h0);
      end
    end
    start(0, 0, 24'h000010);
    wait_end(s);
    check("R11 read while locked", s & 32'h27, 32'h1);

    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk); rst = 1'b0;
    rd(7'h04, s);
    check("R1 reset clears lock", s, 32'h0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule